// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

A synchronous controller that tallies coins for a single-price item costing twenty cents. It takes one-cycle pulses for a nickel, a dime and a quarter. It holds the credit collected so far as one of four levels: 0, 5, 10 or 15 cents. When an accepted coin brings the total to twenty cents or more, the controller releases the item, reports any change owed and drops back to zero credit for the next customer.

The result is a registered three-bit code. The top bit asks the release mechanism to drop the item. The other two bits drive a five-cent dispenser and a ten-cent dispenser, so together they cover refunds of 0, 5, 10 or 15 cents. Change is never more than fifteen cents. Coin validation and the mechanical parts sit outside this block.

Top module: `vend_controller`

## Requirements
- R1: While `rst` is high at a rising edge, the credit becomes 0 and `vend_code` becomes 000 after that edge. Credit collected before a reset is lost.
- R2: An accepted coin adds its value to the credit: nickel 5c, dime 10c, quarter 25c. A total below 20c becomes the new credit and gives code 000.
- R3: When credit plus the coin reaches 20c or more, `vend_code[2]` is 1 and the credit returns to 0.
- R4: Code bits: bit 2 is release, bit 1 returns a 5c coin and bit 0 returns a 10c coin. The legal codes are 000, 100 (no change), 110 (5c), 101 (10c) and 111 (15c).
- R5: The change is credit plus coin minus 20c, capped at 15c. For example, 15c plus a quarter gives 111.
- R6: A cycle with two or three coin pulses high at once is ignored. The credit is held and the code after that edge is 000.
- R7: The code is registered. It appears on the edge that samples the coin pulse, lasts exactly one cycle, and is 000 in every other cycle.
- R8: A cycle with no coin pulse leaves the credit unchanged and gives code 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coin_nickel | input | 1 | One-cycle pulse: 5c coin accepted |
| coin_dime | input | 1 | One-cycle pulse: 10c coin accepted |
| coin_quarter | input | 1 | One-cycle pulse: 25c coin accepted |
| vend_code | output | 3 | Registered release/change code: bit 2 release, bit 1 return 5c, bit 0 return 10c |

## Verification
The bound checker checks these properties on every cycle:
- the reset values;
- that only legal codes appear;
- that every release leaves zero credit and follows a single coin pulse;
- that idle cycles and cycles with clashing coins hold the credit and give 000;
- that a nickel at zero credit moves it to 5c.

Some behaviour only shows over a whole coin sequence at the ports, so the directed scenarios cover it:
- the arithmetic of each path to twenty cents;
- every change code, including the capped 40c case;
- the single-cycle timing of the code;
- the credit that survives a clash or an idle gap.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam logic [2:0] CODE_NONE   = 3'b000;
  localparam logic [2:0] CODE_EXACT  = 3'b100;
  localparam logic [2:0] CODE_BACK5  = 3'b110;
  localparam logic [2:0] CODE_BACK10 = 3'b101;
  localparam logic [2:0] CODE_BACK15 = 3'b111;

  // Overpayment in nickel units -> release/change code, saturating at cap.
  function automatic logic [2:0] change_code(input int unsigned over_units,
                                             input int unsigned cap_units);
    int unsigned lim;
    lim = (over_units > cap_units) ? cap_units : over_units;
    case (lim)
      0:       return CODE_EXACT;
      1:       return CODE_BACK5;
      2:       return CODE_BACK10;
      default: return CODE_BACK15;
    endcase
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode #(
  parameter int unsigned NICKEL_UNITS  = 1,
  parameter int unsigned DIME_UNITS    = 2,
  parameter int unsigned QUARTER_UNITS = 5,
  parameter int unsigned VAL_W         = 3
) (
  input  logic             nickel,
  input  logic             dime,
  input  logic             quarter,
  output logic             one_coin,
  output logic             clash,
  output logic [VAL_W-1:0] value_units
);
  logic [1:0] pulses;

  always_comb begin
    pulses   = 2'(nickel) + 2'(dime) + 2'(quarter);
    one_coin = (pulses == 2'd1);
    clash    = (pulses > 2'd1);
    if (quarter)   value_units = VAL_W'(QUARTER_UNITS);
    else if (dime) value_units = VAL_W'(DIME_UNITS);
    else if (nickel) value_units = VAL_W'(NICKEL_UNITS);
    else           value_units = '0;
  end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
#(
  parameter int unsigned CREDIT_W    = 2,
  parameter int unsigned VAL_W       = 3,
  parameter int unsigned SUM_W       = 4,
  parameter int unsigned PRICE_UNITS = 4,
  parameter int unsigned CAP_UNITS   = 3
) (
  input  logic [CREDIT_W-1:0] credit,
  input  logic                one_coin,
  input  logic [VAL_W-1:0]    value_units,
  output logic [CREDIT_W-1:0] credit_nxt,
  output logic [2:0]          code_nxt,
  output logic                sale
);
  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] over;

  always_comb begin
    total = SUM_W'(credit) + SUM_W'(value_units);
    sale  = one_coin && (total >= SUM_W'(PRICE_UNITS));
    over  = total - SUM_W'(PRICE_UNITS);
    if (sale) begin
      credit_nxt = '0;
      code_nxt   = change_code(32'(over), CAP_UNITS);
    end else if (one_coin) begin
      credit_nxt = total[CREDIT_W-1:0];
      code_nxt   = CODE_NONE;
    end else begin
      credit_nxt = credit;
      code_nxt   = CODE_NONE;
    end
  end
endmodule

// File: rtl/vend_controller.sv
module vend_controller #(
  parameter int unsigned UNIT_CENTS       = 5,
  parameter int unsigned NICKEL_CENTS     = 5,
  parameter int unsigned DIME_CENTS       = 10,
  parameter int unsigned QUARTER_CENTS    = 25,
  parameter int unsigned PRICE_CENTS      = 20,
  parameter int unsigned MAX_CHANGE_CENTS = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coin_nickel,
  input  logic       coin_dime,
  input  logic       coin_quarter,
  output logic [2:0] vend_code
);
  localparam int unsigned PRICE_UNITS   = PRICE_CENTS / UNIT_CENTS;
  localparam int unsigned QUARTER_UNITS = QUARTER_CENTS / UNIT_CENTS;
  localparam int unsigned CREDIT_W      = $clog2(PRICE_UNITS);
  localparam int unsigned VAL_W         = $clog2(QUARTER_UNITS + 1);
  localparam int unsigned SUM_W         = $clog2(PRICE_UNITS + QUARTER_UNITS);
  localparam int unsigned CAP_UNITS     = MAX_CHANGE_CENTS / UNIT_CENTS;

  logic [CREDIT_W-1:0] credit_q, credit_nxt;
  logic [2:0]          code_nxt;
  logic [VAL_W-1:0]    coin_value;
  logic                coin_single, coin_clash, sale_fire;

  vend_coin_decode #(
    .NICKEL_UNITS (NICKEL_CENTS / UNIT_CENTS),
    .DIME_UNITS   (DIME_CENTS / UNIT_CENTS),
    .QUARTER_UNITS(QUARTER_UNITS),
    .VAL_W        (VAL_W)
  ) u_decode (
    .nickel     (coin_nickel),
    .dime       (coin_dime),
    .quarter    (coin_quarter),
    .one_coin   (coin_single),
    .clash      (coin_clash),
    .value_units(coin_value)
  );

  vend_credit_next #(
    .CREDIT_W   (CREDIT_W),
    .VAL_W      (VAL_W),
    .SUM_W      (SUM_W),
    .PRICE_UNITS(PRICE_UNITS),
    .CAP_UNITS  (CAP_UNITS)
  ) u_next (
    .credit     (credit_q),
    .one_coin   (coin_single),
    .value_units(coin_value),
    .credit_nxt (credit_nxt),
    .code_nxt   (code_nxt),
    .sale       (sale_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q  <= '0;
      vend_code <= 3'b000;
    end else begin
      credit_q  <= credit_nxt;
      vend_code <= code_nxt;
    end
  end
endmodule

// File: rtl/vend_controller_chk.sv
module vend_controller_chk #(
  parameter int unsigned CREDIT_W = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                coin_nickel,
  input logic                coin_dime,
  input logic                coin_quarter,
  input logic [2:0]          vend_code,
  input logic [CREDIT_W-1:0] credit_q,
  input logic                coin_clash,
  input logic                sale_fire
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (vend_code == 3'b000 && credit_q == '0));

  assert_nickel_from_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (credit_q == '0 && coin_nickel && !coin_dime && !coin_quarter)
      |=> credit_q == CREDIT_W'(1));

  assert_release_clears_R3: assert property (@(posedge clk) disable iff (rst)
    vend_code[2] |-> credit_q == '0);

  assert_legal_code_R4: assert property (@(posedge clk) disable iff (rst)
    vend_code == 3'b000 || vend_code[2]);

  assert_clash_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    coin_clash |=> (vend_code == 3'b000 && $stable(credit_q)));

  assert_release_after_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    vend_code[2] |-> $past(sale_fire && $countones({coin_nickel, coin_dime, coin_quarter}) == 1));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!coin_nickel && !coin_dime && !coin_quarter)
      |=> (vend_code == 3'b000 && $stable(credit_q)));
endmodule

bind vend_controller vend_controller_chk #(.CREDIT_W(CREDIT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .coin_nickel (coin_nickel),
  .coin_dime   (coin_dime),
  .coin_quarter(coin_quarter),
  .vend_code   (vend_code),
  .credit_q    (credit_q),
  .coin_clash  (coin_clash),
  .sale_fire   (sale_fire)
);

// File: tb/tb_vend_controller.sv
module tb_vend_controller;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cn = 1'b0, cd = 1'b0, cq = 1'b0;
  logic [2:0] vend_code;
  int n_checks = 0;
  int n_fail = 0;
  int credit_m = 0;  // model credit in cents

  always #2 clk = ~clk;  // 250 MHz

  vend_controller dut (
    .clk(clk), .rst(rst),
    .coin_nickel(cn), .coin_dime(cd), .coin_quarter(cq),
    .vend_code(vend_code)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: vend_code=%b expected %b", req, got, exp);
    end
  endtask

  // Independent model of the expected code for a coin of the given cents.
  function automatic logic [2:0] model_code(input int cents);
    int total, chg;
    total = credit_m + cents;
    if (total < 20) return 3'b000;
    chg = total - 20;
    if (chg > 15) chg = 15;
    return {1'b1, (chg == 5 || chg == 15), (chg == 10 || chg == 15)};
  endfunction

  task automatic model_apply(input int cents);
    if (credit_m + cents >= 20) credit_m = 0;
    else credit_m = credit_m + cents;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
    credit_m = 0;
  endtask

  // Pulse coins for one cycle and return the code seen after the sampling edge.
  task automatic pulse(input logic n, input logic d, input logic q, output logic [2:0] got);
    @(negedge clk) begin cn = n; cd = d; cq = q; end
    @(negedge clk) begin cn = 1'b0; cd = 1'b0; cq = 1'b0; end
    got = vend_code;
  endtask

  task automatic coin(input string req, input int cents);
    logic [2:0] got, exp;
    exp = model_code(cents);
    pulse(cents == 5, cents == 10, cents == 25, got);
    check(req, got, exp);
    model_apply(cents);
  endtask

  task automatic t_reset_r1();
    logic [2:0] got;
    do_reset();
    check("R1 reset code", vend_code, 3'b000);
    coin("R2 dime to 10c", 10);
    coin("R2 nickel to 15c", 5);
    do_reset();
    check("R1 code after mid-sale reset", vend_code, 3'b000);
    pulse(1'b0, 1'b1, 1'b0, got);
    check("R1 credit lost on reset", got, 3'b000);
    credit_m = 10;
    coin("R1 sale from 10c after reset", 10);
  endtask

  task automatic t_nickels_r2();
    do_reset();
    coin("R2 nickel 1", 5);
    coin("R2 nickel 2", 5);
    coin("R2 nickel 3", 5);
    coin("R3 fourth nickel sells exact", 5);
    check("R3 exact code value", 3'b100, 3'b100);
  endtask

  task automatic t_dimes_r3();
    do_reset();
    coin("R2 first dime", 10);
    coin("R3 second dime exact 100", 10);
    coin("R3 credit zero after sale", 10);
    coin("R3 next sale", 10);
  endtask

  task automatic t_quarters_r5();
    do_reset();
    coin("R5 quarter from 0c -> 110", 25);
    coin("R2 nickel to 5c", 5);
    coin("R5 quarter from 5c -> 101", 25);
    coin("R2 dime to 10c", 10);
    coin("R5 quarter from 10c -> 111", 25);
    coin("R2 dime", 10);
    coin("R2 nickel to 15c", 5);
    coin("R5 cap: quarter from 15c -> 111", 25);
    coin("R2 nickel", 5);
    coin("R2 dime to 15c", 10);
    coin("R4 dime from 15c -> 110", 10);
  endtask

  task automatic t_clash_r6();
    logic [2:0] got;
    do_reset();
    coin("R2 dime to 10c", 10);
    pulse(1'b1, 1'b1, 1'b0, got);
    check("R6 nickel+dime ignored", got, 3'b000);
    pulse(1'b1, 1'b1, 1'b1, got);
    check("R6 three coins ignored", got, 3'b000);
    pulse(1'b0, 1'b1, 1'b1, got);
    check("R6 dime+quarter ignored", got, 3'b000);
    coin("R6 credit held at 10c", 10);
  endtask

  task automatic t_timing_r7();
    do_reset();
    @(negedge clk) cq = 1'b1;
    #1 check("R7 code not combinational", vend_code, 3'b000);
    @(negedge clk) cq = 1'b0;
    check("R7 code after sampling edge", vend_code, 3'b110);
    @(negedge clk);
    check("R7 code lasts one cycle", vend_code, 3'b000);
    credit_m = 0;
  endtask

  task automatic t_idle_r8();
    do_reset();
    coin("R2 nickel", 5);
    coin("R2 dime to 15c", 10);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R8 idle code", vend_code, 3'b000);
    end
    coin("R8 15c held, nickel sells", 5);
  endtask

  initial begin
    t_reset_r1();
    t_nickels_r2();
    t_dimes_r3();
    t_quarters_r5();
    t_clash_r6();
    t_timing_r7();
    t_idle_r8();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule